// File: doc/BRIEF.md
# Tri-Level Sync and Blank Level Encoder

This block sits beside the pixel path of a three-channel video DAC. It takes three per-pixel control strobes (an active-low sync period flag, an active-high tri-level raise flag and an active-high blank request) and two mode bits. For each output channel it produces a 2-bit level-select code. The code tells the converter stage to pass active video, hold the blanking level, drop to the sync tip or rise to the positive tri-level excursion.

Sync always overrides blanking. One mode bit decides whether sync lands on the luma/green channel alone or on all three channels. The other mode bit chooses between GBR and YPbPr colour spaces. The block also reports the blanking amplitude each channel must use in the selected colour space.

Controls and modes travel through a register pipeline. Its length matches the pixel data path latency, so codes line up with the samples they belong to.

Top module: `tlsync_encoder`

## Requirements
- R1: Every output (level codes and blanking amplitudes) reflects the controls and mode bits sampled exactly LAT rising edges earlier, where LAT defaults to 9. An input set up before edge k shows on the outputs after edge k+LAT-1.
- R2: With sync_n_i low and tri_up_i low (bi-level sync), the luma channel code is 2'b10 (sync tip).
- R3: With sync_n_i low and tri_up_i high, the luma channel code is 2'b11 (positive tri-level excursion).
- R4: While sync_n_i is low, blank_i has no effect on any channel code.
- R5: With sync_n_i high and blank_i high, every channel code is 2'b01 (blank).
- R6: With sync_n_i high and blank_i low, every channel code is 2'b00 (active video).
- R7: While sync_n_i is high, tri_up_i has no effect on any channel code.
- R8: Channel c's code sits at level_code_o[2c+1:2c], and channel 0 is luma/green. During sync with sync_all_i low, channels 1 and 2 carry 2'b01. With sync_all_i high, they carry the same code as channel 0.
- R9: With ypbpr_i low (GBR), every channel's blanking amplitude at blank_level_o[10c+9:10c] equals BLANK_GBR (default 0).
- R10: With ypbpr_i high, channel 0's blanking amplitude is BLANK_LUMA (default 64) and channels 1 and 2 carry BLANK_CHROMA (default 512).
- R11: During reset, and until the first post-reset inputs reach the outputs, all codes are 2'b01 and the amplitudes are the GBR values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n_i | input | 1 | Sync period flag, active low |
| tri_up_i | input | 1 | Positive tri-level excursion request, active high |
| blank_i | input | 1 | Blank request, active high |
| sync_all_i | input | 1 | 1: sync on all channels, 0: luma/green only |
| ypbpr_i | input | 1 | 1: YPbPr blanking amplitudes, 0: GBR |
| level_code_o | output | 6 | Per-channel level code, 2 bits per channel |
| blank_level_o | output | 30 | Per-channel blanking amplitude, 10 bits per channel |

## Verification
The bench builds the encoder with its default parameters: three channels, 10-bit amplitudes, a latency of 9 and channel 0 as luma. With these values it holds every combination of the three strobes for several cycles under each of the four mode settings. It then runs a long random stream in which single-cycle sync pulses and mode flips occur. Because the compare runs on every cycle against a delayed expectation, both an off-by-one latency and a wrong channel route show up immediately.

// File: rtl/tlsync_pkg.sv
`timescale 1ns/1ps
package tlsync_pkg;

    typedef enum logic [1:0] {
        LVL_ACTIVE = 2'b00,
        LVL_BLANK  = 2'b01,
        LVL_TIP    = 2'b10,
        LVL_PEAK   = 2'b11
    } lvl_e;

    typedef struct packed {
        logic sync_n;
        logic tri_up;
        logic blank;
        logic sync_all;
        logic ypbpr;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{sync_n: 1'b1, tri_up: 1'b0, blank: 1'b1,
                                  sync_all: 1'b0, ypbpr: 1'b0};

endpackage

// File: rtl/tlsync_ctl_pipe.sv
`timescale 1ns/1ps
module tlsync_ctl_pipe
    import tlsync_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  ctl_t ctl_i,
    output ctl_t ctl_o
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        ctl_t [STAGES-1:0] stg;
    } pipe_s;

    pipe_s pipe_d, pipe_q;

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.stg[0] = ctl_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d.stg[i] = pipe_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{CTL_IDLE}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign ctl_o = pipe_q.stg[LAST];

endmodule

// File: rtl/tlsync_blank_sel.sv
`timescale 1ns/1ps
module tlsync_blank_sel #(
    parameter int          NCH          = 3,
    parameter int          DAC_W        = 10,
    parameter int          LUMA_CH      = 0,
    parameter int unsigned BLANK_GBR    = 0,
    parameter int unsigned BLANK_LUMA   = 64,
    parameter int unsigned BLANK_CHROMA = 512
) (
    input  logic                   ypbpr_i,
    output logic [NCH*DAC_W-1:0]   level_o
);

    localparam logic [DAC_W-1:0] L_GBR = BLANK_GBR[DAC_W-1:0];
    localparam logic [DAC_W-1:0] L_LUM = BLANK_LUMA[DAC_W-1:0];
    localparam logic [DAC_W-1:0] L_CHR = BLANK_CHROMA[DAC_W-1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c == LUMA_CH) begin : g_luma
            assign level_o[c*DAC_W +: DAC_W] = ypbpr_i ? L_LUM : L_GBR;
        end else begin : g_chroma
            assign level_o[c*DAC_W +: DAC_W] = ypbpr_i ? L_CHR : L_GBR;
        end
    end

endmodule

// File: rtl/tlsync_level_dec.sv
`timescale 1ns/1ps
module tlsync_level_dec
    import tlsync_pkg::*;
#(
    parameter int          NCH          = 3,
    parameter int          DAC_W        = 10,
    parameter int          LUMA_CH      = 0,
    parameter int unsigned BLANK_GBR    = 0,
    parameter int unsigned BLANK_LUMA   = 64,
    parameter int unsigned BLANK_CHROMA = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ctl_t                 ctl_i,
    output logic [2*NCH-1:0]     code_o,
    output logic [NCH*DAC_W-1:0] level_o
);

    localparam logic [DAC_W-1:0] L_GBR = BLANK_GBR[DAC_W-1:0];

    typedef struct packed {
        logic [NCH-1:0][1:0]    code;
        logic [NCH*DAC_W-1:0]   lvl;
    } dec_s;

    dec_s                 dec_d, dec_q;
    logic [NCH-1:0]       gets_sync;
    logic [NCH*DAC_W-1:0] lvl_sel;

    for (genvar c = 0; c < NCH; c++) begin : g_route
        if (c == LUMA_CH) begin : g_fixed
            assign gets_sync[c] = 1'b1;
        end else begin : g_mode
            assign gets_sync[c] = ctl_i.sync_all;
        end
    end

    tlsync_blank_sel #(
        .NCH          (NCH),
        .DAC_W        (DAC_W),
        .LUMA_CH      (LUMA_CH),
        .BLANK_GBR    (BLANK_GBR),
        .BLANK_LUMA   (BLANK_LUMA),
        .BLANK_CHROMA (BLANK_CHROMA)
    ) blank_sel_i (
        .ypbpr_i (ctl_i.ypbpr),
        .level_o (lvl_sel)
    );

    always_comb begin
        dec_d     = dec_q;
        dec_d.lvl = lvl_sel;
        for (int c = 0; c < NCH; c++) begin
            if (!ctl_i.sync_n) begin
                if (gets_sync[c]) begin
                    dec_d.code[c] = ctl_i.tri_up ? LVL_PEAK : LVL_TIP;
                end else begin
                    dec_d.code[c] = LVL_BLANK;
                end
            end else if (ctl_i.blank) begin
                dec_d.code[c] = LVL_BLANK;
            end else begin
                dec_d.code[c] = LVL_ACTIVE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q.code <= {NCH{LVL_BLANK}};
            dec_q.lvl  <= {NCH{L_GBR}};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign code_o  = dec_q.code;
    assign level_o = dec_q.lvl;

endmodule

// File: rtl/tlsync_encoder.sv
`timescale 1ns/1ps
module tlsync_encoder
    import tlsync_pkg::*;
#(
    parameter int          NCH          = 3,
    parameter int          DAC_W        = 10,
    parameter int          LAT          = 9,
    parameter int          LUMA_CH      = 0,
    parameter int unsigned BLANK_GBR    = 0,
    parameter int unsigned BLANK_LUMA   = 64,
    parameter int unsigned BLANK_CHROMA = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_n_i,
    input  logic                 tri_up_i,
    input  logic                 blank_i,
    input  logic                 sync_all_i,
    input  logic                 ypbpr_i,
    output logic [2*NCH-1:0]     level_code_o,
    output logic [NCH*DAC_W-1:0] blank_level_o
);

    localparam int PIPE_STAGES = LAT - 1;

    ctl_t ctl_in;
    ctl_t pipe_tap;

    always_comb begin
        ctl_in.sync_n   = sync_n_i;
        ctl_in.tri_up   = tri_up_i;
        ctl_in.blank    = blank_i;
        ctl_in.sync_all = sync_all_i;
        ctl_in.ypbpr    = ypbpr_i;
    end

    tlsync_ctl_pipe #(
        .STAGES (PIPE_STAGES)
    ) pipe_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl_i (ctl_in),
        .ctl_o (pipe_tap)
    );

    tlsync_level_dec #(
        .NCH          (NCH),
        .DAC_W        (DAC_W),
        .LUMA_CH      (LUMA_CH),
        .BLANK_GBR    (BLANK_GBR),
        .BLANK_LUMA   (BLANK_LUMA),
        .BLANK_CHROMA (BLANK_CHROMA)
    ) dec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_i   (pipe_tap),
        .code_o  (level_code_o),
        .level_o (blank_level_o)
    );

endmodule

// File: rtl/tlsync_encoder_chk.sv
`timescale 1ns/1ps
module tlsync_encoder_chk
    import tlsync_pkg::*;
#(
    parameter int          NCH          = 3,
    parameter int          DAC_W        = 10,
    parameter int          LUMA_CH      = 0,
    parameter int unsigned BLANK_GBR    = 0,
    parameter int unsigned BLANK_LUMA   = 64,
    parameter int unsigned BLANK_CHROMA = 512
) (
    input logic                 clk,
    input logic                 rst_n,
    input ctl_t                 tap,
    input logic [2*NCH-1:0]     code,
    input logic [NCH*DAC_W-1:0] lvl
);

    localparam logic [DAC_W-1:0] L_GBR = BLANK_GBR[DAC_W-1:0];
    localparam logic [DAC_W-1:0] L_LUM = BLANK_LUMA[DAC_W-1:0];
    localparam logic [DAC_W-1:0] L_CHR = BLANK_CHROMA[DAC_W-1:0];

    logic [1:0] luma_code;
    assign luma_code = code[2*LUMA_CH +: 2];

    p_bilevel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tap.sync_n && !tap.tri_up) |=> (luma_code == 2'b10));

    p_trilevel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tap.sync_n && tap.tri_up) |=> (luma_code == 2'b11));

    p_sync_over_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tap.sync_n && tap.blank) |=> luma_code[1]);

    p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tap.sync_n && tap.blank) |=> (code == {NCH{2'b01}}));

    p_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tap.sync_n && !tap.blank) |=> (code == '0));

    p_tri_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tap.sync_n && tap.tri_up) |=> ($countones(code & {NCH{2'b10}}) == 0));

    p_gbr_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tap.ypbpr |=> (lvl == {NCH{L_GBR}}));

    p_ypbpr_luma_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tap.ypbpr |=> (lvl[LUMA_CH*DAC_W +: DAC_W] == L_LUM));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        if (c != LUMA_CH) begin : g_other
            p_route_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!tap.sync_n && !tap.sync_all) |=> (code[2*c +: 2] == 2'b01));

            p_route_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!tap.sync_n && tap.sync_all) |=> (code[2*c +: 2] == luma_code));

            p_ypbpr_chroma_r10: assert property (@(posedge clk) disable iff (!rst_n)
                tap.ypbpr |=> (lvl[c*DAC_W +: DAC_W] == L_CHR));
        end
    end

endmodule

bind tlsync_encoder tlsync_encoder_chk #(
    .NCH          (NCH),
    .DAC_W        (DAC_W),
    .LUMA_CH      (LUMA_CH),
    .BLANK_GBR    (BLANK_GBR),
    .BLANK_LUMA   (BLANK_LUMA),
    .BLANK_CHROMA (BLANK_CHROMA)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tap   (pipe_tap),
    .code  (level_code_o),
    .lvl   (blank_level_o)
);

// File: tb/tlsync_encoder_tb_top.sv
`timescale 1ns/1ps
module tlsync_encoder_tb_top;
    import tlsync_pkg::*;

    localparam int NCH   = 3;
    localparam int DAC_W = 10;
    localparam int LAT   = 9;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sync_n_i = 1'b1;
    logic                 tri_up_i = 1'b0;
    logic                 blank_i = 1'b1;
    logic                 sync_all_i = 1'b0;
    logic                 ypbpr_i = 1'b0;
    logic [2*NCH-1:0]     level_code_o;
    logic [NCH*DAC_W-1:0] blank_level_o;

    int   n_checks = 0;
    int   n_errors = 0;
    int   t = LAT;
    ctl_t hist [16];
    ctl_t prev_exp = CTL_IDLE;

    always #2.5 clk = ~clk;

    tlsync_encoder dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_n_i      (sync_n_i),
        .tri_up_i      (tri_up_i),
        .blank_i       (blank_i),
        .sync_all_i    (sync_all_i),
        .ypbpr_i       (ypbpr_i),
        .level_code_o  (level_code_o),
        .blank_level_o (blank_level_o)
    );

    function automatic logic [1:0] exp_code(ctl_t e, int c);
        if (!e.sync_n) begin
            if (c != 0 && !e.sync_all) return 2'b01;
            return e.tri_up ? 2'b11 : 2'b10;
        end
        return e.blank ? 2'b01 : 2'b00;
    endfunction

    function automatic logic [DAC_W-1:0] exp_lvl(ctl_t e, int c);
        if (!e.ypbpr) return 10'd0;
        return (c == 0) ? 10'd64 : 10'd512;
    endfunction

    function automatic string code_tag(ctl_t e, int c);
        if (!e.sync_n) begin
            if (c != 0) return "R8";
            if (e.tri_up) return "R3";
            if (e.blank) return "R4";
            return "R2";
        end
        if (e.tri_up) return "R7";
        if (e.blank) return "R5";
        return "R6";
    endfunction

    task automatic check_outputs(ctl_t e, string pre);
        for (int c = 0; c < NCH; c++) begin
            logic [1:0]       ac = level_code_o[2*c +: 2];
            logic [1:0]       ec = exp_code(e, c);
            logic [DAC_W-1:0] al = blank_level_o[c*DAC_W +: DAC_W];
            logic [DAC_W-1:0] el = exp_lvl(e, c);
            string            lt = e.ypbpr ? "R10" : "R9";
            n_checks++;
            if (ac !== ec) begin
                n_errors++;
                $display("FAIL %s%s ch%0d code: actual=%b expected=%b at t=%0d",
                         pre, code_tag(e, c), c, ac, ec, t);
            end
            n_checks++;
            if (al !== el) begin
                n_errors++;
                $display("FAIL %s%s ch%0d level: actual=%0d expected=%0d at t=%0d",
                         pre, lt, c, al, el, t);
            end
        end
    endtask

    task automatic step(ctl_t nc);
        ctl_t  e;
        string pre;
        @(negedge clk);
        e = hist[(t - LAT) % 16];
        if (t < 2 * LAT) pre = "R11/";
        else if (e != prev_exp) pre = "R1/";
        else pre = "";
        check_outputs(e, pre);
        prev_exp = e;
        hist[t % 16] = nc;
        sync_n_i   = nc.sync_n;
        tri_up_i   = nc.tri_up;
        blank_i    = nc.blank;
        sync_all_i = nc.sync_all;
        ypbpr_i    = nc.ypbpr;
        t++;
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        ctl_t c;
        for (int i = 0; i < 16; i++) hist[i] = CTL_IDLE;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_outputs(CTL_IDLE, "R11/");
        rst_n = 1'b1;

        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 8; k++) begin
                c.sync_all = m[0];
                c.ypbpr    = m[1];
                c.sync_n   = k[2];
                c.tri_up   = k[1];
                c.blank    = k[0];
                repeat (3) step(c);
            end
        end

        c = '{sync_n: 1'b1, tri_up: 1'b0, blank: 1'b0, sync_all: 1'b1, ypbpr: 1'b1};
        repeat (12) step(c);
        c.sync_n = 1'b0;
        c.tri_up = 1'b1;
        step(c);
        c.sync_n = 1'b1;
        c.tri_up = 1'b0;
        repeat (12) step(c);

        c = CTL_IDLE;
        for (int i = 0; i < 3000; i++) begin
            int unsigned r = $urandom;
            if (r[5:0] == 6'd0) c.sync_all = ~c.sync_all;
            if (r[11:6] == 6'd0) c.ypbpr = ~c.ypbpr;
            c.sync_n = (r[14:12] != 3'd0);
            c.tri_up = r[15];
            c.blank  = r[16] | r[17];
            step(c);
        end

        repeat (LAT + 2) step(CTL_IDLE);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule